// File: doc/BRIEF.md
# HDLC Receive Deframer with Length Filter

This block takes the octet stream recovered from a SONET/SDH payload and turns it into framed packets for a downstream receive FIFO. Frame boundaries are the 0x7E flag octets, which never reach the output. A 0x7D escape octet is dropped and the octet after it has bit 5 inverted (XOR 0x20). Every forwarded octet, FCS octets included, carries start-of-frame and end-of-frame markers. A frame that cannot be delivered whole ends with an abort marker instead.

The frame length is counted after escapes are removed, with the FCS octets included. It is checked against a programmable maximum and, when enabled, a programmable minimum. A frame is also aborted when the illegal pair 0x7D 0x7E arrives or when the downstream FIFO reports an overflow. After an abort the rest of the frame is dropped up to the next flag. Two saturating counters record frames dropped as too long and as too short. A transparent mode bypasses all framing.

A frame's last octet is only known when its closing flag arrives. The block therefore holds one destuffed octet back. A data octet is emitted on the clock after the next data octet of the same frame, or after the closing flag, arrives.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While rst_n is low on a clock edge, all outputs are cleared after that edge, both counters read 0, and the block then waits for a flag before it accepts a frame.
- R2: Outside transparent mode, 0x7E octets are never forwarded. The data octets between two flags come out in order, one clock after the following data octet or the closing flag arrives. The first octet has out_sof=1 and the last has out_eof=1; a one-octet frame has both. Adjacent flags produce no output.
- R3: A 0x7D octet is not forwarded and increments no length. The next octet, unless it is 0x7E, is forwarded XOR 0x20 and counts as one octet.
- R4: The pair 0x7D 0x7E produces, one clock later, an abort beat: out_valid=1, out_abort=1, out_data=0, out_sof=0, out_eof=0. The held octet is dropped, no counter moves, and that 0x7E opens the next frame.
- R5: When accepting a data octet would make the destuffed length greater than or equal to max_len, an abort beat is emitted, long_cnt increments, and every octet up to the next flag is dropped.
- R6: With min_en=1, a closing flag that ends a frame of 1 to min_len-1 destuffed octets emits an abort beat instead of the last octet, and short_cnt increments. With min_en=0 no minimum applies.
- R7: A fifo_ovf pulse while a frame is in progress (at least one octet or a pending escape taken since the last flag) emits an abort beat, and octets up to the next flag are dropped. A pulse with no frame in progress has no effect.
- R8: Each counter stops at its all-ones value. cnt_clr zeroes both counters, and an increment in the same cycle leaves the counter at 1.
- R9: With transparent=1, every input octet appears unchanged on out_data one clock later with out_valid=1 and no markers. After transparent falls, octets are dropped until a flag arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input octet present |
| in_data | input | 8 | Input octet from the payload |
| transparent | input | 1 | Bypass all framing |
| min_en | input | 1 | Enable the minimum length check |
| max_len | input | MAX_W | Frames reaching this destuffed length are aborted |
| min_len | input | MIN_W | Frames shorter than this are aborted when min_en=1 |
| fifo_ovf | input | 1 | Downstream FIFO overflow pulse |
| cnt_clr | input | 1 | Read strobe that clears both counters |
| out_valid | output | 1 | Output beat present |
| out_data | output | 8 | Destuffed octet (0 on an abort beat) |
| out_sof | output | 1 | First octet of a frame |
| out_eof | output | 1 | Last octet of a good frame |
| out_abort | output | 1 | Frame aborted |
| short_cnt | output | CNT_W | Frames dropped as too short |
| long_cnt | output | CNT_W | Frames dropped as too long |

## Verification
The bench builds the block with CNT_W=4 and the default 16-bit maximum and 7-bit minimum widths. The narrow counters reach saturation after fifteen short frames, so the hold at all-ones and the clear that coincides with an increment are both tested in a short run. Small values of max_len and min_len put the boundary frames (one octet under, at, and over each limit, with escaped octets counted once) within a few octets of stimulus.

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int MAX_W = 16,
  parameter int MIN_W = 7,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             transparent,
  input  logic             min_en,
  input  logic [MAX_W-1:0] max_len,
  input  logic [MIN_W-1:0] min_len,
  input  logic             fifo_ovf,
  input  logic             cnt_clr,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_abort,
  output logic [CNT_W-1:0] short_cnt,
  output logic [CNT_W-1:0] long_cnt
);
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [7:0] ESC  = 8'h7D;

  logic             disc, esc;
  logic [MAX_W-1:0] len;
  logic [7:0]       pend;

  wire is_flag = in_data == FLAG;
  wire is_esc  = in_data == ESC;
  wire busy    = (len != '0) || esc;
  wire ovf_abt = fifo_ovf && !transparent && !disc && busy;
  wire live    = in_valid && !transparent && !disc && !ovf_abt;
  wire take    = live && !is_flag && (esc || !is_esc);
  wire [MAX_W:0] nlen = {1'b0, len} + 1'b1;
  wire too_long  = take && (nlen >= {1'b0, max_len});
  wire bad_seq   = live && esc && is_flag;
  wire close     = live && !esc && is_flag && (len != '0);
  wire too_short = close && min_en && (len < {{(MAX_W-MIN_W){1'b0}}, min_len});
  wire abort     = ovf_abt || bad_seq || too_long || too_short;
  wire [7:0] dbyte = esc ? (in_data ^ 8'h20) : in_data;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic inc, input logic clr);
    if (clr)                     return inc ? CNT_W'(1) : '0;
    else if (inc && (c != '1))   return c + 1'b1;
    else                         return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disc <= 1'b1; esc <= 1'b0; len <= '0; pend <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eof <= 1'b0; out_abort <= 1'b0;
      short_cnt <= '0; long_cnt <= '0;
    end else begin
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eof <= 1'b0; out_abort <= 1'b0;
      if (transparent) begin
        out_valid <= in_valid;
        out_data  <= in_data;
      end else if (abort) begin
        out_valid <= 1'b1;
        out_abort <= 1'b1;
      end else if (close) begin
        out_valid <= 1'b1; out_data <= pend; out_sof <= (len == MAX_W'(1)); out_eof <= 1'b1;
      end else if (take && (len != '0)) begin
        out_valid <= 1'b1; out_data <= pend; out_sof <= (len == MAX_W'(1));
      end

      if (transparent || ovf_abt || too_long) begin
        disc <= 1'b1; esc <= 1'b0; len <= '0;
      end else if (in_valid) begin
        if (disc) begin
          if (is_flag) disc <= 1'b0;
        end else if (is_flag) begin
          esc <= 1'b0; len <= '0;
        end else if (!esc && is_esc) begin
          esc <= 1'b1;
        end else begin
          esc <= 1'b0; pend <= dbyte; len <= nlen[MAX_W-1:0];
        end
      end

      short_cnt <= bump(short_cnt, too_short, cnt_clr);
      long_cnt  <= bump(long_cnt,  too_long,  cnt_clr);
    end
  end
endmodule

module hdlc_rx_deframer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             transparent,
  input logic             cnt_clr,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic             out_abort,
  input logic [CNT_W-1:0] short_cnt,
  input logic [CNT_W-1:0] long_cnt
);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_sof && !out_eof && !out_abort && out_data == 8'h00));

  p_flag_no_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!transparent && in_valid && in_data == 8'h7E) |=> (!out_valid || out_eof || out_abort));

  p_abort_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> (out_valid && !out_sof && !out_eof && out_data == 8'h00));

  p_long_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (long_cnt == $past(long_cnt) || (out_abort && long_cnt == $past(long_cnt) + 1'b1)));

  p_short_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (short_cnt == $past(short_cnt) || (out_abort && short_cnt == $past(short_cnt) + 1'b1)));

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (short_cnt == '1 && !cnt_clr) |=> short_cnt == '1);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (short_cnt <= CNT_W'(1) && long_cnt <= CNT_W'(1)));

  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (transparent && in_valid) |=> (out_valid && out_data == $past(in_data) && !out_sof && !out_eof && !out_abort));
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .transparent(transparent), .cnt_clr(cnt_clr), .out_valid(out_valid),
  .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort),
  .short_cnt(short_cnt), .long_cnt(long_cnt)
);

// File: tb/sim_hdlc_rx_deframer.sv
`timescale 1ns/1ps
module sim_hdlc_rx_deframer;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic transparent = 1'b0, min_en = 1'b0, fifo_ovf = 1'b0, cnt_clr = 1'b0;
  logic [15:0] max_len = 16'hFFFF;
  logic [6:0]  min_len = '0;
  logic out_valid, out_sof, out_eof, out_abort;
  logic [7:0] out_data;
  logic [CNT_W-1:0] short_cnt, long_cnt;

  hdlc_rx_deframer #(.MAX_W(16), .MIN_W(7), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .transparent(transparent), .min_en(min_en), .max_len(max_len), .min_len(min_len),
    .fifo_ovf(fifo_ovf), .cnt_clr(cnt_clr), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort),
    .short_cnt(short_cnt), .long_cnt(long_cnt));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit started = 0;

  // behavioural reference model
  byte unsigned fq[$];
  bit m_disc = 1, m_esc = 0;
  int m_short = 0, m_long = 0;
  int e_v, e_d, e_s, e_e, e_a;

  task automatic m_abort();
    e_v = 1; e_a = 1; e_d = 0; e_s = 0; e_e = 0;
    fq.delete(); m_esc = 0;
  endtask

  always @(posedge clk) begin
    int inc_s, inc_l;
    byte unsigned b;
    e_v = 0; e_d = 0; e_s = 0; e_e = 0; e_a = 0; inc_s = 0; inc_l = 0;
    started = 1;
    if (!rst_n) begin
      fq.delete(); m_disc = 1; m_esc = 0; m_short = 0; m_long = 0;
    end else begin
      if (transparent) begin
        if (in_valid) begin e_v = 1; e_d = in_data; end
        fq.delete(); m_disc = 1; m_esc = 0;
      end else if (fifo_ovf && !m_disc && (fq.size() > 0 || m_esc)) begin
        m_abort(); m_disc = 1;
      end else if (in_valid) begin
        if (m_disc) begin
          if (in_data == 8'h7E) m_disc = 0;
        end else if (m_esc && in_data == 8'h7E) begin
          m_abort();
        end else if (in_data == 8'h7E) begin
          if (fq.size() > 0) begin
            if (min_en && fq.size() < int'(min_len)) begin m_abort(); inc_s = 1; end
            else begin e_v = 1; e_d = fq[fq.size()-1]; e_s = (fq.size() == 1); e_e = 1; end
          end
          fq.delete();
        end else if (!m_esc && in_data == 8'h7D) begin
          m_esc = 1;
        end else begin
          b = m_esc ? (in_data ^ 8'h20) : in_data;
          m_esc = 0;
          if (fq.size() + 1 >= int'(max_len)) begin m_abort(); inc_l = 1; m_disc = 1; end
          else begin
            fq.push_back(b);
            if (fq.size() >= 2) begin e_v = 1; e_d = fq[fq.size()-2]; e_s = (fq.size() == 2); end
          end
        end
      end
      if (cnt_clr) begin m_short = inc_s; m_long = inc_l; end
      else begin
        if (inc_s && m_short < CMAX) m_short++;
        if (inc_l && m_long < CMAX) m_long++;
      end
    end
  end

  task automatic chk(string what, int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("out_valid", out_valid, e_v, cur_req);
      chk("out_data",  out_data,  e_d, cur_req);
      chk("out_sof",   out_sof,   e_s, cur_req);
      chk("out_eof",   out_eof,   e_e, cur_req);
      chk("out_abort", out_abort, e_a, cur_req);
      chk("short_cnt", short_cnt, m_short, "R6/R8");
      chk("long_cnt",  long_cnt,  m_long, "R5/R8");
    end
  end

  task automatic step(input bit v, input byte unsigned d);
    in_valid = v; in_data = d;
    @(negedge clk);
    in_valid = 0; in_data = 0; cnt_clr = 0; fifo_ovf = 0;
  endtask
  task automatic tx(input byte unsigned d); step(1, d); endtask
  task automatic gap(); step(0, 8'h00); endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: cleared outputs and counters during reset
    chk("reset out_valid", out_valid, 0, "R1");
    chk("reset short_cnt", short_cnt, 0, "R1");
    chk("reset long_cnt",  long_cnt,  0, "R1");
    rst_n = 1;
    tx(8'h11); tx(8'h22);                    // R1: dropped before the first flag

    cur_req = "R2";
    tx(8'h7E); tx(8'hA1); gap(); tx(8'hB2); gap(); gap(); tx(8'hC3); tx(8'h7E);
    tx(8'h7E); tx(8'h7E); tx(8'h55); tx(8'h7E); gap(); gap();

    cur_req = "R3";
    tx(8'h7D); tx(8'h5E); tx(8'h7D); tx(8'h5D); tx(8'h7D); tx(8'h31); tx(8'h7E); gap();

    cur_req = "R4";
    tx(8'h11); tx(8'h22); tx(8'h7D); tx(8'h7E); tx(8'h33); tx(8'h44); tx(8'h7E);
    tx(8'h7D); tx(8'h7E); tx(8'h7E); gap();

    cur_req = "R5";
    max_len = 16'd4;
    tx(8'h01); tx(8'h02); tx(8'h03); tx(8'h04); tx(8'h05); tx(8'h7E);
    tx(8'h7D); tx(8'h5E); tx(8'h09); tx(8'h0A); tx(8'h7E);
    tx(8'h7E); max_len = 16'd1; tx(8'h66); tx(8'h7E); max_len = 16'hFFFF; gap();

    cur_req = "R6";
    min_en = 1; min_len = 7'd3;
    tx(8'h21); tx(8'h22); tx(8'h7E);
    tx(8'h31); tx(8'h7D); tx(8'h5D); tx(8'h33); tx(8'h7E);
    min_en = 0; tx(8'h41); tx(8'h7E); gap();

    cur_req = "R7";
    tx(8'h51); tx(8'h52); fifo_ovf = 1; gap(); tx(8'h53); tx(8'h7E);
    fifo_ovf = 1; gap(); tx(8'h61); tx(8'h7E);
    tx(8'h7D); fifo_ovf = 1; gap(); tx(8'h70); tx(8'h7E); gap();

    cur_req = "R8";
    min_en = 1; min_len = 7'd2;
    for (int i = 0; i < CMAX + 3; i++) begin tx(8'h10); tx(8'h7E); end
    chk("short saturated", short_cnt, CMAX, "R8");
    cnt_clr = 1; gap();
    chk("cleared", short_cnt, 0, "R8");
    tx(8'h10); cnt_clr = 1; tx(8'h7E);
    chk("clear with increment", short_cnt, 1, "R8");
    min_en = 0; gap();

    cur_req = "R9";
    transparent = 1;
    tx(8'h7E); tx(8'h7D); tx(8'h5E); gap(); tx(8'h00); fifo_ovf = 1; tx(8'hFF);
    transparent = 0;
    tx(8'h12); tx(8'h34); tx(8'h7E); tx(8'h56); tx(8'h78); tx(8'h7E); gap(); gap();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule